// File: doc/BRIEF.md
# Cascaded channel interrupt aggregator

The block gathers interrupt events from 32 channel sources and drives one summary line into a parent interrupt controller. Each channel owns a 4-bit event-cause register whose bits are set by per-channel event strobes. A channel-level status bit in a shared 32-bit status register is set whenever any event strobe of that channel fires. A 32-bit enable register masks channels. The effective pending set is status AND enable. The summary line reports whether that set is non-empty. A helper output gives the highest-numbered pending channel, so a dispatcher can pick one channel per pass.

Clearing works in two levels. Software first clears the cause bits of a channel by writing ones to them, and only then can it clear the channel's status bit. A status clear request made while the cause register is non-zero is dropped. This keeps the cause reason visible to the handler until it has been consumed.

Register offsets: status 0x00, enable 0x04, cause of channel c at 0x10 + 4*c. Reads return zero-extended data one cycle after the request.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset, status, enable and every cause register are zero, irq_o is low, pend_valid_o is low and rdata_o is zero.
- R2: An event strobe on bit b of channel c (ev_i[4*c+b]) sets cause bit b of channel c and status bit c in the next cycle.
- R3: Writing to a cause register clears each cause bit written as 1 and leaves bits written as 0 unchanged. An event strobe on the same bit in the same cycle wins and the bit stays set.
- R4: Writing status at 0x00 requests a clear of each bit c written as 1. The clear takes effect only if channel c's cause register is zero in that cycle. Bits written as 0 are unchanged.
- R5: An event strobe on channel c in the same cycle as an accepted status clear of bit c leaves status bit c set.
- R6: The enable register at 0x04 is plain read/write. Changing an enable bit does not alter any status bit.
- R7: irq_o is high exactly when at least one bit of status AND enable is 1.
- R8: pend_idx_o gives the highest-numbered set bit of status AND enable. pend_valid_o is high exactly when that set is non-empty.
- R9: A read with rd_en_i returns in the next cycle: status at 0x00, enable at 0x04, cause of channel c in bits 3:0 at 0x10+4*c with the upper bits zero, and zero for any other address. rdata_o holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 128 | Event strobes, channel c bit b at index 4*c+b |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Summary interrupt to parent controller |
| pend_idx_o | output | 5 | Highest pending enabled channel |
| pend_valid_o | output | 1 | pend_idx_o is meaningful |

## Verification
Single-channel events check the basic set path and the index encoder in isolation. Simultaneous events on low and high channels, followed by masking the highest one, separate a highest-first encoder from a lowest-first or stale one. Status clear attempts are made with the cause register non-zero, after it is cleared, and together with a fresh event, which separates the interlock from a plain write-1-to-clear and shows that the set path has priority. A long random mix of events, writes and reads, including unmapped and misaligned addresses, is compared every cycle against a behavioural model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned STAT_OFF   = 32'h00;
  localparam int unsigned EN_OFF     = 32'h04;
  localparam int unsigned CAUSE_BASE = 32'h10;
  localparam int unsigned DEF_NUM_CH = 32;
  localparam int unsigned DEF_CAUSE_W = 4;
endpackage

// File: rtl/irq_agg_chan.sv
module irq_agg_chan #(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] ev_i,
  input  logic               cause_wr_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  input  logic               stat_clr_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               stat_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               stat_q, stat_d;
  logic               ev_any;

  assign ev_any = |ev_i;

  always_comb begin
    cause_d = cause_q;
    if (cause_wr_i) cause_d = cause_q & ~cause_clr_i;
    cause_d = cause_d | ev_i;
  end

  // set wins; clear only when cause is empty
  always_comb begin
    stat_d = stat_q;
    if (ev_any) stat_d = 1'b1;
    else if (stat_clr_i && (cause_q == '0)) stat_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      stat_q  <= stat_d;
    end
  end

  assign cause_o = cause_q;
  assign stat_o  = stat_q;

  p_ev_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_any |=> (stat_o && ((cause_o & $past(ev_i)) == $past(ev_i))));

  p_cause_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_wr_i && (ev_i == '0)) |=> ((cause_o & $past(cause_clr_i)) == '0));

  p_clr_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && stat_clr_i && (cause_o != '0)) |=> stat_o);

  p_clr_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && (cause_o == '0) && !ev_any) |=> !stat_o);

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && ev_any) |=> stat_o);

  p_stat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_any && !stat_clr_i) |=> $stable(stat_o));
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned CAUSE_W = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_CH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NUM_CH-1:0]         stat_i,
  input  logic [NUM_CH*CAUSE_W-1:0] cause_i,
  output logic [NUM_CH-1:0]         en_o,
  output logic [NUM_CH-1:0]         cause_wr_o,
  output logic [CAUSE_W-1:0]        cause_clr_o,
  output logic [NUM_CH-1:0]         stat_clr_o,
  output logic [DATA_W-1:0]         rdata_o
);
  logic              hit_stat, hit_en, hit_cause;
  logic [ADDR_W-1:0] cause_off;
  logic [IDX_W-1:0]  cause_sel;
  logic [NUM_CH-1:0] en_q;
  logic [DATA_W-1:0] rd_val, rdata_q;

  assign hit_stat  = (addr_i == ADDR_W'(STAT_OFF));
  assign hit_en    = (addr_i == ADDR_W'(EN_OFF));
  assign cause_off = addr_i - ADDR_W'(CAUSE_BASE);
  assign hit_cause = (addr_i >= ADDR_W'(CAUSE_BASE)) && (cause_off[1:0] == 2'b00) &&
                     (cause_off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_CH));
  assign cause_sel = cause_off[IDX_W+1:2];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      cause_wr_o[c] = wr_en_i && hit_cause && (cause_sel == IDX_W'(c));
    end
  end

  assign cause_clr_o = wdata_i[CAUSE_W-1:0];
  assign stat_clr_o  = (wr_en_i && hit_stat) ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_en_i && hit_en) en_q <= wdata_i[NUM_CH-1:0];
  end
  assign en_o = en_q;

  always_comb begin
    rd_val = '0;
    if (hit_stat) rd_val[NUM_CH-1:0] = stat_i;
    else if (hit_en) rd_val[NUM_CH-1:0] = en_q;
    else if (hit_cause) rd_val[CAUSE_W-1:0] = cause_i[cause_sel*CAUSE_W +: CAUSE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  p_en_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_en) |=> (en_o == $past(wdata_i[NUM_CH-1:0])));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_one_cause_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_wr_o));
endmodule

// File: rtl/irq_agg_prienc.sv
module irq_agg_prienc #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  // later iterations override: highest index wins
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned CAUSE_W = DEF_CAUSE_W,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_CH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH*CAUSE_W-1:0] ev_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      irq_o,
  output logic [IDX_W-1:0]          pend_idx_o,
  output logic                      pend_valid_o
);
  logic [NUM_CH-1:0]         stat, en, pending, cause_wr, stat_clr;
  logic [NUM_CH*CAUSE_W-1:0] cause;
  logic [CAUSE_W-1:0]        cause_clr;

  irq_agg_regif #(
    .NUM_CH(NUM_CH), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .stat_i(stat), .cause_i(cause), .en_o(en), .cause_wr_o(cause_wr),
    .cause_clr_o(cause_clr), .stat_clr_o(stat_clr), .rdata_o
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irq_agg_chan #(.CAUSE_W(CAUSE_W)) u_chan (
      .clk_i, .rst_ni,
      .ev_i(ev_i[c*CAUSE_W +: CAUSE_W]),
      .cause_wr_i(cause_wr[c]),
      .cause_clr_i(cause_clr),
      .stat_clr_i(stat_clr[c]),
      .cause_o(cause[c*CAUSE_W +: CAUSE_W]),
      .stat_o(stat[c])
    );
  end

  assign pending = stat & en;
  assign irq_o   = |pending;

  irq_agg_prienc #(.N(NUM_CH)) u_enc (
    .req_i(pending), .idx_o(pend_idx_o), .valid_o(pend_valid_o)
  );

  p_irq_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == pend_valid_o);

  p_idx_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> pending[pend_idx_o]);

  p_idx_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> ((pending >> pend_idx_o) == NUM_CH'(1)));
endmodule

// File: tb/irq_cascade_agg_tb.sv
module irq_cascade_agg_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH = 32;
  localparam int CW = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NCH*CW-1:0] ev_i = '0;
  logic            wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]      addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            irq_o, pend_valid_o;
  logic [4:0]      pend_idx_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  bit [31:0] m_stat, m_en, m_rdata;
  bit [3:0]  m_cause [NCH];

  always #(CLK_P/2) clk = ~clk;

  irq_cascade_agg dut_i (
    .clk_i(clk), .rst_ni, .ev_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .pend_idx_o, .pend_valid_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a == 8'h00) return m_stat;
    if (a == 8'h04) return m_en;
    if (a >= 8'h10 && a[1:0] == 2'b00 && ((a - 8'h10) >> 2) < NCH)
      return {28'b0, m_cause[(a - 8'h10) >> 2]};
    return 32'h0;
  endfunction

  function automatic bit [31:0] m_pend();
    return m_stat & m_en;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat = 0; m_en = 0; m_rdata = 0;
      for (int c = 0; c < NCH; c++) m_cause[c] = 0;
    end else begin
      bit [31:0] ns;
      bit [3:0]  nc [NCH];
      ns = m_stat;
      if (rd_en_i) m_rdata = m_read(addr_i);
      for (int c = 0; c < NCH; c++) begin
        bit [3:0] e;
        e = ev_i[c*CW +: CW];
        nc[c] = m_cause[c];
        if (wr_en_i && addr_i == 8'(8'h10 + 4*c)) nc[c] = nc[c] & ~wdata_i[3:0];
        nc[c] = nc[c] | e;
        if (e != 0) ns[c] = 1'b1;
        else if (wr_en_i && addr_i == 8'h00 && wdata_i[c] && m_cause[c] == 0) ns[c] = 1'b0;
      end
      if (wr_en_i && addr_i == 8'h04) m_en = wdata_i;
      m_stat = ns;
      for (int c = 0; c < NCH; c++) m_cause[c] = nc[c];
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && cmp_on) begin
      int top;
      top = -1;
      for (int i = 0; i < NCH; i++) if (m_pend()[i]) top = i;
      chk(irq_o == (m_pend() != 0), "R7", {31'b0, irq_o}, {31'b0, m_pend() != 0});
      chk(pend_valid_o == (top >= 0), "R8", {31'b0, pend_valid_o}, {31'b0, top >= 0});
      if (top >= 0) chk(pend_idx_o == 5'(top), "R8", {27'b0, pend_idx_o}, top);
      chk(rdata_o == m_rdata, "R9", rdata_o, m_rdata);
    end
  end

  task automatic cyc();
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0; ev_i = '0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
  endtask

  task automatic rd_chk(input bit [7:0] a, input bit [31:0] exp, input string req);
    rd_en_i = 1'b1; addr_i = a;
    cyc();
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset state
    chk(irq_o == 1'b0, "R1", {31'b0, irq_o}, 0);
    chk(pend_valid_o == 1'b0, "R1", {31'b0, pend_valid_o}, 0);
    chk(rdata_o == 0, "R1", rdata_o, 0);
    rd_chk(8'h00, 0, "R1");
    rd_chk(8'h04, 0, "R1");
    rd_chk(8'h8C, 0, "R1");

    // R6 enable r/w
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'hFFFF_FFFF, "R6");

    // R2 single event ch5 bit0
    ev_i[5*CW + 0] = 1'b1; cyc();
    chk(irq_o == 1'b1, "R2", {31'b0, irq_o}, 1);
    chk(pend_idx_o == 5'd5, "R8", {27'b0, pend_idx_o}, 5);
    rd_chk(8'h24, 32'h1, "R2");

    // R8 highest wins
    ev_i[9*CW + 2] = 1'b1; ev_i[30*CW + 3] = 1'b1; cyc();
    chk(pend_idx_o == 5'd30, "R8", {27'b0, pend_idx_o}, 30);
    rd_chk(8'h00, 32'h4000_0220, "R2");

    // R6 masking does not touch status
    wr(8'h04, ~(32'h1 << 30));
    chk(pend_idx_o == 5'd9, "R8", {27'b0, pend_idx_o}, 9);
    rd_chk(8'h00, 32'h4000_0220, "R6");

    // R4 clear blocked while cause non-zero
    wr(8'h00, 32'h0000_0200);
    rd_chk(8'h00, 32'h4000_0220, "R4");
    // R3 write-0 leaves, write-1 clears
    wr(8'h34, 32'h0);
    rd_chk(8'h34, 32'h4, "R3");
    wr(8'h34, 32'h4);
    rd_chk(8'h34, 32'h0, "R3");
    wr(8'h00, 32'h0000_0200);
    rd_chk(8'h00, 32'h4000_0020, "R4");

    // R5 event beats accepted clear
    wr(8'h24, 32'hF);
    wr_en_i = 1'b1; addr_i = 8'h00; wdata_i = 32'h20; ev_i[5*CW + 3] = 1'b1; cyc();
    rd_chk(8'h00, 32'h4000_0020, "R5");
    // R3 event beats cause clear
    wr_en_i = 1'b1; addr_i = 8'h24; wdata_i = 32'h8; ev_i[5*CW + 3] = 1'b1; cyc();
    rd_chk(8'h24, 32'h8, "R3");

    // R9 unmapped and misaligned reads
    rd_chk(8'h08, 0, "R9");
    rd_chk(8'h11, 0, "R9");
    rd_chk(8'h90, 0, "R9");
    rd_chk(8'hFC, 0, "R9");

    // R7 irq drops when all pending masked
    wr(8'h04, 32'h0);
    chk(irq_o == 1'b0, "R7", {31'b0, irq_o}, 0);

    // random mix, checked each cycle against the model
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) ev_i[$urandom_range(0, NCH*CW-1)] = 1'b1;
      if (r == 3 || r == 4) begin
        wr_en_i = 1'b1;
        case ($urandom_range(0, 2))
          0: begin addr_i = 8'h00; wdata_i = $urandom; end
          1: begin addr_i = 8'h04; wdata_i = $urandom; end
          default: begin addr_i = 8'(8'h10 + 4*$urandom_range(0, NCH-1)); wdata_i = $urandom; end
        endcase
      end
      if (r >= 5) begin
        rd_en_i = 1'b1;
        if (!wr_en_i) addr_i = 8'($urandom_range(0, 160));
      end
      cyc();
    end
    finish_run();
  end
endmodule